// File: doc/BRIEF.md
# Table-driven gate evaluation processor

This block evaluates a compiled gate netlist one gate per clock. Each instruction names four operand signals, a destination signal, a function code and a fifth signal to send out. Every signal is a 2-bit word holding one of four logic levels. The gate result comes only from a lookup in a writable truth-table memory. The index of that lookup is the function code joined to the four operand values. There is no arithmetic, no branch and no condition. After a start pulse the block steps through slots 0 to `last_slot` in order, then pulses `cycle_done` and stops.

The state store has two halves that trade places at the end of every evaluation cycle. A normal operand reads the half that the previous cycle wrote, so each gate advances one delay per cycle. An operand with its same-cycle flag set reads the half being written now, so it sees results made by earlier slots of the current cycle. This lets combinational logic settle in one cycle while storage elements keep their unit delay.

Values received from an interconnect land in an input region that shares the operand address space. Each slot also drives one chosen signal back out. A single load port fills the instruction memory, the truth tables and the initial state while the block is idle.

Top module: `gate_eval_core`

## Requirements
- R1: After reset the block is idle: `busy`=0, `slot`=0, `phase`=0, `tx_valid`=0 and `cycle_done`=0. Every state and input location holds the undefined code 2'b10. Values are coded 00 = logic 0, 01 = logic 1, 10 = undefined, 11 = high impedance.
- R2: A slot writes to data location `dst` the truth-table entry at index {func, v3, v2, v1, v0}, where vi is the value of operand i. The table holds 2^(3+8) entries of 2 bits.
- R3: A start pulse while idle runs slots 0 to `last_slot` (sampled at start) in increasing order, one per clock, starting the clock after start. `tx_valid`=1 for exactly those clocks. `last_slot`=0 runs a single slot.
- R4: The clock after the last slot, `cycle_done` is high for one clock, `phase` inverts and the block is idle again. A start while busy has no effect.
- R5: An operand with its same-cycle flag clear reads the half selected by `phase`, so it sees values written in the previous evaluation cycle.
- R6: An operand with its same-cycle flag set reads the half being written, so it sees values written by earlier slots of the same cycle.
- R7: In each running slot `tx_data` is the value at the fifth address. That address is read under its own same-cycle flag before the slot's write.
- R8: Operand address bit 5 set selects the input region; bit 5 clear selects the data region, and bits 4:0 give the location. In slot k, `rx_data` is stored at input location k of the half being written.
- R9: Instruction layout, LSB first: src0[5:0], src1[11:6], src2[17:12], src3[23:18], flag for source i at bit 24+i, tx address [33:28], tx flag [34], dst [39:35], func [42:40]. Load selects: 0 instruction at `ld_addr`, 1 table entry, 2 state word written to both halves of data location `ld_addr`. A load while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 2 | Load target: instruction, table or state |
| ld_addr | input | 11 | Load address |
| ld_data | input | 43 | Load data (instruction word, or value in bits 1:0) |
| last_slot | input | 5 | Index of the final slot of a cycle |
| start | input | 1 | Begins one evaluation cycle |
| rx_data | input | 2 | Value arriving from the interconnect for the current slot |
| busy | output | 1 | Evaluation cycle in progress |
| slot | output | 5 | Slot being executed |
| phase | output | 1 | Half read by normal operands |
| tx_valid | output | 1 | `tx_data` carries this slot's value |
| tx_data | output | 2 | Selected value sent to the interconnect |
| cycle_done | output | 1 | One-clock pulse ending a cycle |

## Verification
The assertions check the sequencing on every clock. They cover slot stepping and the idle slot, the single-clock done pulse with its phase flip, and that no load reaches state storage while gates write. The bench's reference model is needed to show the memory semantics: unit-delay propagation along a chain, same-cycle settling, received values seen both in the same cycle and one cycle late, table lookups over random programs, and that loads and starts issued mid-cycle change nothing.

// File: rtl/gev_pkg.sv
package gev_pkg;
    localparam int VAL_W   = 2;
    localparam int SIG_AW  = 6;
    localparam int DATA_AW = SIG_AW - 1;
    localparam int SLOT_W  = DATA_AW;
    localparam int FUNC_W  = 3;
    localparam int NSRC    = 4;
    localparam int NRD     = NSRC + 1;
    localparam int TBL_AW  = FUNC_W + NSRC * VAL_W;
    localparam int LD_AW   = TBL_AW;

    localparam logic [VAL_W-1:0] VAL_UNDEF = 2'b10;

    typedef enum logic [1:0] {
        LD_INSTR = 2'd0,
        LD_TABLE = 2'd1,
        LD_STATE = 2'd2
    } ld_sel_e;

    typedef struct packed {
        logic [FUNC_W-1:0]             func;
        logic [DATA_AW-1:0]            dst;
        logic                          tx_fast;
        logic [SIG_AW-1:0]             tx_src;
        logic [NSRC-1:0]               fast;
        logic [NSRC-1:0][SIG_AW-1:0]   src;
    } gate_instr_t;

    localparam int INSTR_W = $bits(gate_instr_t);
endpackage

// File: rtl/gev_seq.sv
module gev_seq
    import gev_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SLOT_W-1:0] last_slot,
    output logic              busy,
    output logic [SLOT_W-1:0] slot,
    output logic              phase,
    output logic              done
);
    typedef struct packed {
        logic              busy;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] lim;
        logic              phase;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy = 1'b1;
                seq_d.slot = '0;
                seq_d.lim  = last_slot;
            end
        end else if (seq_q.slot == seq_q.lim) begin
            seq_d.busy  = 1'b0;
            seq_d.slot  = '0;
            seq_d.phase = ~seq_q.phase;
            seq_d.done  = 1'b1;
        end else begin
            seq_d.slot = seq_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy  = seq_q.busy;
    assign slot  = seq_q.slot;
    assign phase = seq_q.phase;
    assign done  = seq_q.done;

    // R4: completion lasts exactly one clock
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: completion coincides with a phase swap
    assert_done_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase != $past(phase)));

    // R3: a running cycle steps by one slot and stays busy until the limit
    assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (slot != seq_q.lim)) |=> (busy && (slot == SLOT_W'($past(slot) + 1'b1))));

    // R3: idle slot index is zero
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (slot == '0));
endmodule

// File: rtl/gev_state_mem.sv
module gev_state_mem
    import gev_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         phase,
    input  logic [NRD-1:0][SIG_AW-1:0]   rd_addr,
    input  logic [NRD-1:0]               rd_fast,
    output logic [NRD-1:0][VAL_W-1:0]    rd_val,
    input  logic                         wr_en,
    input  logic [DATA_AW-1:0]           wr_addr,
    input  logic [VAL_W-1:0]             wr_val,
    input  logic                         rx_en,
    input  logic [DATA_AW-1:0]           rx_addr,
    input  logic [VAL_W-1:0]             rx_val,
    input  logic                         ld_en,
    input  logic [DATA_AW-1:0]           ld_addr,
    input  logic [VAL_W-1:0]             ld_val
);
    localparam int DEPTH = 2 ** DATA_AW;

    logic [VAL_W-1:0] dat_mem [2][DEPTH];
    logic [VAL_W-1:0] in_mem  [2][DEPTH];
    logic             wr_half;

    assign wr_half = ~phase;

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        logic half;
        assign half = rd_fast[i] ? wr_half : phase;
        assign rd_val[i] = rd_addr[i][SIG_AW-1]
                         ? in_mem[half][rd_addr[i][DATA_AW-1:0]]
                         : dat_mem[half][rd_addr[i][DATA_AW-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int h = 0; h < 2; h++) begin
                for (int a = 0; a < DEPTH; a++) begin
                    dat_mem[h][a] <= VAL_UNDEF;
                    in_mem[h][a]  <= VAL_UNDEF;
                end
            end
        end else begin
            if (wr_en) dat_mem[wr_half][wr_addr] <= wr_val;
            if (rx_en) in_mem[wr_half][rx_addr]  <= rx_val;
            if (ld_en) begin
                dat_mem[0][ld_addr] <= ld_val;
                dat_mem[1][ld_addr] <= ld_val;
            end
        end
    end

    // R9: state loads never collide with gate writes
    assert_load_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> !wr_en);
endmodule

// File: rtl/gev_func_table.sv
module gev_func_table
    import gev_pkg::*;
(
    input  logic                        clk,
    input  logic                        ld_en,
    input  logic [TBL_AW-1:0]           ld_addr,
    input  logic [VAL_W-1:0]            ld_val,
    input  logic [FUNC_W-1:0]           func,
    input  logic [NSRC-1:0][VAL_W-1:0]  ops,
    output logic [VAL_W-1:0]            result
);
    localparam int ENTRIES = 2 ** TBL_AW;

    logic [VAL_W-1:0] tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (ld_en) tbl[ld_addr] <= ld_val;
    end

    assign result = tbl[{func, ops}];
endmodule

// File: rtl/gate_eval_core.sv
module gate_eval_core
    import gev_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [1:0]         ld_sel,
    input  logic [LD_AW-1:0]   ld_addr,
    input  logic [INSTR_W-1:0] ld_data,
    input  logic [SLOT_W-1:0]  last_slot,
    input  logic               start,
    input  logic [VAL_W-1:0]   rx_data,
    output logic               busy,
    output logic [SLOT_W-1:0]  slot,
    output logic               phase,
    output logic               tx_valid,
    output logic [VAL_W-1:0]   tx_data,
    output logic               cycle_done
);
    localparam int SLOTS = 2 ** SLOT_W;

    logic [INSTR_W-1:0]              imem [SLOTS];
    gate_instr_t                     cur;
    logic                            ld_ok;
    logic [NRD-1:0][SIG_AW-1:0]      rd_addr;
    logic [NRD-1:0]                  rd_fast;
    logic [NRD-1:0][VAL_W-1:0]       rd_val;
    logic [NSRC-1:0][VAL_W-1:0]      ops;
    logic [VAL_W-1:0]                gate_val;

    assign ld_ok = ld_en && !busy;

    gev_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_slot (last_slot),
        .busy      (busy),
        .slot      (slot),
        .phase     (phase),
        .done      (cycle_done)
    );

    always_ff @(posedge clk) begin
        if (ld_ok && (ld_sel == LD_INSTR)) imem[ld_addr[SLOT_W-1:0]] <= ld_data;
    end

    assign cur = gate_instr_t'(imem[slot]);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign rd_addr[i] = cur.src[i];
        assign rd_fast[i] = cur.fast[i];
        assign ops[i]     = rd_val[i];
    end
    assign rd_addr[NSRC] = cur.tx_src;
    assign rd_fast[NSRC] = cur.tx_fast;

    gev_state_mem u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .rd_addr (rd_addr),
        .rd_fast (rd_fast),
        .rd_val  (rd_val),
        .wr_en   (busy),
        .wr_addr (cur.dst),
        .wr_val  (gate_val),
        .rx_en   (busy),
        .rx_addr (slot),
        .rx_val  (rx_data),
        .ld_en   (ld_ok && (ld_sel == LD_STATE)),
        .ld_addr (ld_addr[DATA_AW-1:0]),
        .ld_val  (ld_data[VAL_W-1:0])
    );

    gev_func_table u_tbl (
        .clk     (clk),
        .ld_en   (ld_ok && (ld_sel == LD_TABLE)),
        .ld_addr (ld_addr[TBL_AW-1:0]),
        .ld_val  (ld_data[VAL_W-1:0]),
        .func    (cur.func),
        .ops     (ops),
        .result  (gate_val)
    );

    assign tx_valid = busy;
    assign tx_data  = rd_val[NSRC];

    // R4: done only follows a running clock
    assert_done_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> $past(busy));
endmodule

// File: tb/gate_eval_core_tb_top.sv
module gate_eval_core_tb_top;
    import gev_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ld_en = 1'b0;
    logic [1:0]         ld_sel = '0;
    logic [LD_AW-1:0]   ld_addr = '0;
    logic [INSTR_W-1:0] ld_data = '0;
    logic [SLOT_W-1:0]  last_slot = '0;
    logic               start = 1'b0;
    logic [VAL_W-1:0]   rx_data;
    logic               busy, phase, tx_valid, cycle_done;
    logic [SLOT_W-1:0]  slot;
    logic [VAL_W-1:0]   tx_data;

    int n_tests = 0;
    int n_fail  = 0;
    int run_idx = 0;
    int observed = 0;
    string cur_tag = "R1";

    logic [1:0] exp_q[$];
    logic [1:0] m_tbl [2 ** TBL_AW];
    logic [1:0] m_dat [2][32];
    logic [1:0] m_in  [2][32];
    bit         m_ph = 1'b0;

    int        pf  [32];
    int        pd  [32];
    bit        ptf [32];
    int        pts [32];
    bit [3:0]  pfa [32];
    int        ps  [32][4];

    always #10 clk = ~clk;

    function automatic logic [1:0] rxv(int k, int r);
        return 2'(k * 3 + r);
    endfunction

    assign rx_data = rxv(int'(slot), run_idx);

    gate_eval_core dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .last_slot(last_slot),
        .start(start), .rx_data(rx_data), .busy(busy), .slot(slot),
        .phase(phase), .tx_valid(tx_valid), .tx_data(tx_data),
        .cycle_done(cycle_done)
    );

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bench truth tables, index = {func, v3, v2, v1, v0}
    function automatic logic [1:0] tfun(int f, int idx);
        logic [1:0] v0, v1, v2, v3;
        v0 = idx[1:0]; v1 = idx[3:2]; v2 = idx[5:4]; v3 = idx[7:6];
        case (f)
            0: return (v0 == 0 || v1 == 0) ? 2'd0 : (v0 == 1 && v1 == 1) ? 2'd1 : 2'd2;
            1: return (v0 == 0) ? 2'd1 : (v0 == 1) ? 2'd0 : 2'd2;
            2: return v0;
            3: return (v0 == 1 || v1 == 1) ? 2'd1 : (v0 == 0 && v1 == 0) ? 2'd0 : 2'd2;
            4: return v0 ^ v1 ^ v2;
            5: return v3;
            6: return v0 ^ v3 ^ {v1[0], v2[1]};
            default: return 2'((idx * 37) >> 3);
        endcase
    endfunction

    function automatic logic [1:0] mrd(int a, bit f);
        bit h;
        h = f ? !m_ph : m_ph;
        return (a >= 32) ? m_in[h][a - 32] : m_dat[h][a];
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            observed++;
            if (exp_q.size() == 0) check({cur_tag, " unexpected slot"}, 1, 0);
            else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check({cur_tag, " tx value"}, int'(tx_data), int'(e));
            end
        end
    end

    task automatic ld(input logic [1:0] s, input int a, input logic [INSTR_W-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s; ld_addr = LD_AW'(a); ld_data = d;
    endtask

    task automatic ld_end();
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_prog();
        gate_instr_t w;
        for (int k = 0; k < 32; k++) begin
            w = '0;
            w.func = FUNC_W'(pf[k]);
            w.dst = DATA_AW'(pd[k]);
            w.tx_fast = ptf[k];
            w.tx_src = SIG_AW'(pts[k]);
            w.fast = pfa[k];
            for (int i = 0; i < 4; i++) w.src[i] = SIG_AW'(ps[k][i]);
            ld(LD_INSTR, k, w);
        end
        ld_end();
    endtask

    task automatic load_state();
        for (int i = 0; i < 32; i++) begin
            logic [1:0] v;
            v = (i == 31) ? 2'd0 : 2'((i * 5) % 4);
            m_dat[0][i] = v; m_dat[1][i] = v;
            ld(LD_STATE, i, INSTR_W'(v));
        end
        ld_end();
    endtask

    task automatic chain_prog(bit fast);
        for (int k = 0; k < 32; k++) begin
            pf[k] = (k == 3) ? 0 : 1;
            pd[k] = k + 1;
            ps[k][0] = k; ps[k][1] = (k == 3) ? 0 : 31;
            ps[k][2] = 31; ps[k][3] = 31;
            pfa[k] = fast ? 4'b0001 : 4'b0000;
            pts[k] = k + 1; ptf[k] = fast;
        end
        load_prog();
    endtask

    task automatic run(string tag, int L, bit poke);
        bit ph0;
        logic [1:0] v [4];
        ph0 = m_ph;
        for (int k = 0; k <= L; k++) begin
            logic [1:0] res;
            for (int i = 0; i < 4; i++) v[i] = mrd(ps[k][i], pfa[k][i]);
            res = m_tbl[{3'(pf[k]), v[3], v[2], v[1], v[0]}];
            exp_q.push_back(mrd(pts[k], ptf[k]));
            m_dat[!m_ph][pd[k]] = res;
            m_in[!m_ph][k] = rxv(k, run_idx);
        end
        cur_tag = tag;
        observed = 0;
        @(negedge clk);
        last_slot = SLOT_W'(L); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start = 1'b1;
            ld_en = 1'b1; ld_sel = LD_TABLE; ld_addr = LD_AW'(256); ld_data = '0;
            @(negedge clk);
            start = 1'b0; ld_en = 1'b0;
        end
        while (cycle_done !== 1'b1) @(negedge clk);
        check("R4 phase flips", int'(phase), int'(!ph0));
        check("R4 idle at done", int'(busy), 0);
        check("R3 slot count", observed, L + 1);
        check("R3 queue drained", exp_q.size(), 0);
        @(negedge clk);
        check("R4 done single pulse", int'(cycle_done), 0);
        m_ph = !m_ph;
        run_idx++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int h = 0; h < 2; h++)
            for (int a = 0; a < 32; a++) begin m_dat[h][a] = 2'd2; m_in[h][a] = 2'd2; end
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 slot", int'(slot), 0);
        check("R1 phase", int'(phase), 0);
        check("R1 tx_valid", int'(tx_valid), 0);
        check("R1 cycle_done", int'(cycle_done), 0);
        rst_n = 1'b1;

        // R9: table load
        for (int i = 0; i < 2 ** TBL_AW; i++) begin
            m_tbl[i] = tfun(i >> 8, i & 255);
            ld(LD_TABLE, i, INSTR_W'(m_tbl[i]));
        end
        ld_end();

        chain_prog(1'b0);
        run("R1 undefined state", 3, 1'b0);

        load_state();
        run("R5", 3, 1'b0);
        run("R9 mid-run load ignored", 3, 1'b1);
        run("R5", 3, 1'b0);
        run("R5", 3, 1'b0);

        chain_prog(1'b1);
        load_state();
        run("R6", 3, 1'b0);
        run("R6", 3, 1'b0);

        for (int k = 0; k < 32; k++) begin
            pf[k] = 2; pd[k] = 10 + k;
            ps[k][0] = (k == 0) ? 32 : 32 + k - 1;
            ps[k][1] = 31; ps[k][2] = 31; ps[k][3] = 31;
            pfa[k] = 4'b0001;
            pts[k] = 32 + k; ptf[k] = k[0];
        end
        load_prog();
        run("R8", 5, 1'b0);
        run("R8", 5, 1'b0);
        run("R8", 5, 1'b0);
        run("R3 single slot", 0, 1'b0);

        for (int p = 0; p < 5; p++) begin
            for (int k = 0; k < 32; k++) begin
                pf[k] = $urandom_range(0, 7);
                pd[k] = $urandom_range(0, 31);
                for (int i = 0; i < 4; i++) ps[k][i] = $urandom_range(0, 63);
                pfa[k] = 4'($urandom_range(0, 15));
                pts[k] = $urandom_range(0, 63);
                ptf[k] = 1'($urandom_range(0, 1));
            end
            load_prog();
            for (int c = 0; c < 3; c++) run("R2/R7", $urandom_range(1, 31), 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule